// File: doc/BRIEF.md
# Dual-Mode Programmable Pulse Generator

This block produces rectangular waveforms from two 8-bit reload counters. Each counter owns two reload registers, one for the width of the low phase and one for the width of the high phase. When a counter runs out it flips its output and reloads from the register of the phase it is entering. Low and high times are therefore set separately.

A mode input arranges the counters in one of three ways. In split mode they are two independent 8-bit generators. In wide mode they form one 16-bit generator whose widths join the registers of both lanes. In prescale mode the first counter divides the count clock and the second generates the waveform. All counting advances on a count tick. The tick is taken from the system clock divided by 1, 2, 4, 8 or 16, or from an external slow base tick.

Each generator is a three-state machine. The states are ST_HOLD (disabled, output low, low width loaded), ST_LOW and ST_HIGH. The transitions are:
- enable high, which moves ST_HOLD to ST_LOW, or straight to ST_HIGH if the count is already zero on a tick.
- underflow on a tick with count zero, which moves ST_LOW to ST_HIGH and ST_HIGH to ST_LOW.
- enable low, which moves any state to ST_HOLD.

A sticky interrupt flag records underflows.

Top module: `ppg_dual`

## Requirements
- R1: After reset both bits of `pulse_out` are 0 and `irq` is 0.
- R2: While `enable` is 0 both output bits are 0 from the next cycle onward, and the low width is reloaded. With clock select 0, after `enable` returns to 1 the first rise appears on the (lo+1)th rising clock edge at which `enable` is seen high.
- R3: Split mode, `mode` = 0. Lane 0 drives `pulse_out[0]` and lane 1 drives `pulse_out[1]`. Each output stays low for lo+1 count ticks and high for hi+1 count ticks, where lo and hi are that lane's registers.
- R4: Wide mode, `mode` = 1. The 16-bit low width is {lo1, lo0} and the 16-bit high width is {hi1, hi0}. Both output bits carry the same waveform, low for low+1 ticks and high for high+1 ticks.
- R5: Prescale mode, `mode` = 2. Lane 0 reloads lo0 for both of its phases, so it ticks lane 1 once every lo0+1 count ticks. Both output bits carry lane 1. Lane 1 is low for (lo1+1)·(lo0+1) count ticks and high for (hi1+1)·(lo0+1) count ticks. hi0 has no effect.
- R6: Clock select value s from 0 to 4 makes one count tick every 2^s clock cycles. Values 5 to 7 use one count tick per cycle in which `base_tick` is 1.
- R7: The `irq` flag sets on an underflow. In split mode that is an underflow of either lane; in wide mode, of the 16-bit counter; in prescale mode, of lane 1. The flag stays set until cleared.
- R8: A write to address 4 clears `irq`. If an underflow occurs in the same cycle, the flag stays set.
- R9: Register addresses are 0 = lo0, 1 = hi0, 2 = lo1 and 3 = hi1. A new value takes effect at the next reload of that phase, even while running.
- R10: `mode` = 3 behaves exactly as split mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| mode | input | 2 | Counter arrangement: 0 split, 1 wide, 2 prescale, 3 split |
| clk_sel | input | 3 | Count-clock select |
| base_tick | input | 1 | Slow external tick, one cycle wide |
| enable | input | 1 | Run enable |
| pulse_out | output | 2 | Pulse outputs |
| irq | output | 1 | Sticky underflow flag |

## Verification
A wrong count or a wrong reload shows up as a pulse width that is wrong at the pins. It appears within one waveform period of the fault, so the bench measures full high and low phases for many width pairs, divider settings and all modes. A machine stuck outside ST_HOLD shows as a pin that does not drop on the cycle after `enable` falls. A missing reload shows as a wrong first-rise delay after re-enable. A flag that does not hold or clear is visible on `irq` one cycle after the event or the clearing write.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        MODE_SPLIT     = 2'd0,
        MODE_WIDE      = 2'd1,
        MODE_PRESCALE  = 2'd2,
        MODE_SPLIT_ALT = 2'd3
    } mode_t;

    localparam int ADDR_IRQ_CLR = 4;

endpackage

// File: rtl/ppg_tick_sel.sv
module ppg_tick_sel #(
    parameter int DIV_W = 4,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic             base_tick,
    output logic             tick
);
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(DIV_W);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   mask_w;
    logic [DIV_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   div_q <= '0;
        else if (!run) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end

    always_comb begin
        mask_w = ((DIV_W+1)'(1) << sel) - (DIV_W+1)'(1);
        mask   = mask_w[DIV_W-1:0];
        if (!run)               tick = 1'b0;
        else if (sel > SEL_MAX) tick = base_tick;
        else                    tick = ((div_q & mask) == mask);
    end

    // R6: divide-by-2 never ticks on two consecutive cycles
    p_div2_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sel == SEL_W'(1) && tick) |=> !(run && sel == SEL_W'(1) && tick));

endmodule

// File: rtl/ppg_gen.sv
module ppg_gen
    import ppg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] lo_w,
    input  logic [W-1:0] hi_w,
    output logic         out,
    output logic         uf
);
    phase_t       state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        uf      = 1'b0;
        if (!en) begin
            state_d = ST_HOLD;
            cnt_d   = lo_w;
        end else if (tick) begin
            if (cnt_q == '0) begin
                uf = 1'b1;
                unique case (state_q)
                    ST_HIGH: begin state_d = ST_LOW;  cnt_d = lo_w; end
                    ST_HOLD,
                    ST_LOW:  begin state_d = ST_HIGH; cnt_d = hi_w; end
                    default: begin state_d = ST_HOLD; cnt_d = lo_w; end
                endcase
            end else begin
                cnt_d = cnt_q - 1'b1;
                if (state_q == ST_HOLD) state_d = ST_LOW;
            end
        end else if (state_q == ST_HOLD) begin
            state_d = ST_LOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb out = (state_q == ST_HIGH);

    // R3: the output level moves only on an underflow tick
    p_quiet_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(out));
    // R3: every underflow flips the output
    p_uf_toggles_r3: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> (out != $past(out)));

endmodule

// File: rtl/ppg_dual.sv
module ppg_dual
    import ppg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int DIV_W  = 4,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        mode,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              base_tick,
    input  logic              enable,
    output logic [1:0]        pulse_out,
    output logic              irq
);
    localparam int LANES  = 2;
    localparam int WIDE_W = LANES * DATA_W;

    logic [LANES-1:0][DATA_W-1:0] lo_q, hi_q, lane_hi;
    logic [LANES-1:0]             lane_tick, lane_out, lane_uf;
    logic                         cnt_tick, lanes_en, wide_en;
    logic                         wide_out, wide_uf;
    logic                         is_wide, is_pre, uf_event, irq_clr, irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_addr == ADDR_W'(2*i))     lo_q[i] <= wr_data;
                if (wr_addr == ADDR_W'(2*i + 1)) hi_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        is_wide  = (mode == MODE_WIDE);
        is_pre   = (mode == MODE_PRESCALE);
        lanes_en = enable && !is_wide;
        wide_en  = enable && is_wide;
    end

    ppg_tick_sel #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(enable), .sel(clk_sel),
        .base_tick(base_tick), .tick(cnt_tick)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign lane_tick[g] = cnt_tick;
            assign lane_hi[g]   = is_pre ? lo_q[g] : hi_q[g];
        end else begin : g_next
            assign lane_tick[g] = is_pre ? lane_uf[g-1] : cnt_tick;
            assign lane_hi[g]   = hi_q[g];
        end
        ppg_gen #(.W(DATA_W)) u_gen (
            .clk(clk), .rst_n(rst_n), .en(lanes_en), .tick(lane_tick[g]),
            .lo_w(lo_q[g]), .hi_w(lane_hi[g]),
            .out(lane_out[g]), .uf(lane_uf[g])
        );
    end

    ppg_gen #(.W(WIDE_W)) u_wide (
        .clk(clk), .rst_n(rst_n), .en(wide_en), .tick(cnt_tick),
        .lo_w(lo_q), .hi_w(hi_q), .out(wide_out), .uf(wide_uf)
    );

    always_comb begin
        if (is_wide)     pulse_out = {wide_out, wide_out};
        else if (is_pre) pulse_out = {lane_out[1], lane_out[1]};
        else             pulse_out = lane_out;

        if (is_wide)     uf_event = wide_uf;
        else if (is_pre) uf_event = lane_uf[1];
        else             uf_event = |lane_uf;

        irq_clr = wr_en && (wr_addr == ADDR_W'(ADDR_IRQ_CLR));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        irq_q <= 1'b0;
        else if (uf_event) irq_q <= 1'b1;
        else if (irq_clr)  irq_q <= 1'b0;
    end

    assign irq = irq_q;

    // R2: disabling drives both pins low on the next cycle
    p_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pulse_out == 2'b00));
    // R7: an underflow leaves the flag set
    p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uf_event |=> irq);
    // R7: the flag holds until a clearing write
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
    // R8: a clearing write with no underflow drops the flag
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !uf_event) |=> !irq);

endmodule

// File: tb/ppg_dual_test.sv
module ppg_dual_test;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIMIT = 3000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] mode;
    logic [2:0] clk_sel;
    logic       base_tick;
    logic       enable;
    logic [1:0] pulse_out;
    logic       irq;

    int  errors = 0;
    int  checks = 0;
    bit  base_run = 1'b0;
    bit  done = 1'b0;

    ppg_dual uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode), .clk_sel(clk_sel),
        .base_tick(base_tick), .enable(enable),
        .pulse_out(pulse_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int bcnt = 0;
        base_tick = 1'b0;
        forever begin
            @(negedge clk);
            bcnt++;
            base_tick = base_run && (bcnt % 4 == 0);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic write_reg(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(addr);
        wr_data = 8'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic setup(input int m, input int s, input int l0, input int h0,
                         input int l1, input int h1);
        @(negedge clk);
        enable = 1'b0;
        write_reg(0, l0);
        write_reg(1, h0);
        write_reg(2, l1);
        write_reg(3, h1);
        mode    = 2'(m);
        clk_sel = 3'(s);
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic wait_level(input int pin, input bit lvl, output bit ok);
        int n = 0;
        ok = 1'b1;
        while (pulse_out[pin] != lvl) begin
            @(negedge clk);
            n++;
            if (n > WAIT_LIMIT) begin ok = 1'b0; return; end
        end
    endtask

    // counts samples of one full high phase and the following low phase
    task automatic measure(input int pin, output int hi_n, output int lo_n);
        bit ok;
        hi_n = -1;
        lo_n = -1;
        wait_level(pin, 1'b0, ok); if (!ok) return;
        wait_level(pin, 1'b1, ok); if (!ok) return;
        hi_n = 0;
        while (pulse_out[pin] == 1'b1 && hi_n <= WAIT_LIMIT) begin
            @(negedge clk); hi_n++;
        end
        lo_n = 0;
        while (pulse_out[pin] == 1'b0 && lo_n <= WAIT_LIMIT) begin
            @(negedge clk); lo_n++;
        end
    endtask

    task automatic expect_wave(input string tag, input int pin,
                               input int exp_hi, input int exp_lo);
        int h, l;
        measure(pin, h, l);
        chk($sformatf("%s pin%0d high", tag, pin), h, exp_hi);
        chk($sformatf("%s pin%0d low", tag, pin), l, exp_lo);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        int vals_a[4] = '{0, 1, 3, 7};
        int vals_b[3] = '{0, 2, 5};
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        mode = 2'd0; clk_sel = 3'd0; enable = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pulse_out after reset", int'(pulse_out), 0);
        chk("R1 irq after reset", int'(irq), 0);

        // R3: split mode width sweep, both lanes with different widths
        foreach (vals_a[i]) begin
            foreach (vals_b[j]) begin
                setup(0, 0, vals_a[i], vals_b[j], vals_b[j], vals_a[i]);
                expect_wave("R3 split", 0, vals_b[j] + 1, vals_a[i] + 1);
                expect_wave("R3 split", 1, vals_a[i] + 1, vals_b[j] + 1);
            end
        end

        // R6: divider sweep, one tick every 2^s cycles
        for (int s = 0; s <= 4; s++) begin
            setup(0, s, 2, 1, 0, 0);
            expect_wave($sformatf("R6 div sel=%0d", s), 0, 2 * (1 << s), 3 * (1 << s));
        end
        // R6: base tick every 4 cycles, selects 5 and 7
        base_run = 1'b1;
        setup(0, 5, 2, 1, 0, 0);
        expect_wave("R6 base sel=5", 0, 8, 12);
        setup(0, 7, 1, 3, 0, 0);
        expect_wave("R6 base sel=7", 0, 16, 8);
        base_run = 1'b0;

        // R4: wide mode, borrow across the byte boundary
        setup(1, 0, 8'h00, 8'h05, 8'h01, 8'h00);
        expect_wave("R4 wide", 0, 6, 257);
        expect_wave("R4 wide", 1, 6, 257);
        setup(1, 0, 8'h2A, 8'h00, 8'h00, 8'h01);
        expect_wave("R4 wide", 0, 257, 43);

        // R5: prescale mode, hi0 ignored
        setup(2, 0, 2, 9, 1, 3);
        expect_wave("R5 prescale", 0, 12, 6);
        expect_wave("R5 prescale", 1, 12, 6);
        setup(2, 1, 2, 200, 1, 3);
        expect_wave("R5 prescale div2", 1, 24, 12);

        // R10: mode 3 as split
        setup(3, 0, 1, 4, 2, 0);
        expect_wave("R10 mode3", 0, 5, 2);
        expect_wave("R10 mode3", 1, 1, 3);

        // R9: rewrite high width while running
        setup(0, 0, 1, 1, 0, 0);
        expect_wave("R9 before write", 0, 2, 2);
        write_reg(1, 6);
        expect_wave("R9 after write", 0, 7, 2);

        // R2: disable mid-phase, pins low, then first rise after lo+1 edges
        for (int k = 0; k < 2; k++) begin
            int n;
            setup(0, 0, 4, 2, 4, 2);
            repeat (7 + 2 * k) @(negedge clk);
            enable = 1'b0;
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                chk("R2 pins low while disabled", int'(pulse_out), 0);
            end
            enable = 1'b1;
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (pulse_out[0] == 1'b0 && n < WAIT_LIMIT);
            chk("R2 first rise delay", n, 5);
        end

        // R7: flag set by earlier underflows and sticky while idle
        @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 irq sticky", int'(irq), 1);
        // R8: clear by write to address 4
        write_reg(4, 0);
        chk("R8 irq cleared", int'(irq), 0);
        repeat (3) @(negedge clk);
        chk("R8 irq stays clear", int'(irq), 0);

        // R7: wide mode, no flag before the first 16-bit underflow
        setup(1, 0, 8'h00, 8'h03, 8'h01, 8'h00);
        write_reg(4, 0);
        repeat (20) @(negedge clk);
        chk("R7 wide irq before underflow", int'(irq), 0);
        expect_wave("R7 wide", 0, 4, 257);
        chk("R7 wide irq after underflow", int'(irq), 1);

        enable = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule